// File: doc/BRIEF.md
# Incremental Rule Update Engine

This block maintains the membership tables of a bit-vector packet classifier and edits them one rule at a time, with no full rebuild of the tables. The classifier key is cut into 13 chunks of 8 bits. Each chunk has a table with one entry per chunk value, and each entry holds one bit per rule slot. At lookup time the classifier ANDs together the 13 words read for a packet. Software turns each rule field into a range before it issues a command. A prefix becomes low = address AND mask and high = low OR NOT mask, and a full-length mask gives an exact value.

An add command carries 13 inclusive byte ranges. The engine claims the lowest unused slot. It then walks chunk 0 through chunk 12 and, from each chunk's low value to its high value, ORs a one-hot word for that slot into the entry. That is one read-modify-write per clock. A delete command carries a slot number and the same 13 ranges. The engine frees the slot first, then walks the ranges and ANDs each entry with the inverted one-hot word. A registered lookup port reads any table entry, which is the path the classifier uses.

States: `S_IDLE` waits for a command. `S_WALK` performs the writes. `S_DONE` raises `done` for one cycle and reports the result. The transitions are as follows. `S_IDLE`→`S_WALK` on an accepted command that can proceed. `S_IDLE`→`S_DONE` on an add while every slot is used, or on a delete of an unused slot. `S_WALK`→`S_WALK` while ranges remain. `S_WALK`→`S_DONE` once chunk 12 reaches its high value or is found empty. `S_DONE`→`S_IDLE` always.

Top module: `rule_update_engine`

## Requirements
- R1: After reset every table entry reads all zeros, no slot is in use, and `busy` and `done` are low.
- R2: An add is given the lowest-numbered unused slot, and `done_id` reports it with `done_status` 0 (success).
- R3: An add sets the slot's bit in every entry from low to high inclusive in each of the 13 chunks, and in no other entry.
- R4: An add while all slots are in use reports `done_status` 1 (table full) with `done` one cycle after acceptance, and leaves every table entry unchanged.
- R5: A delete of a used slot clears that slot's bit over its ranges and reports status 0. The slot becomes free, so the next add receives it again.
- R6: A delete of an unused slot reports `done_status` 2 (no such rule) with `done` one cycle after acceptance, and changes no entry.
- R7: A chunk whose low value exceeds its high value is an empty range: no entry of that chunk is written.
- R8: Bits belonging to other slots are never changed by an add or a delete.
- R9: One entry is written per cycle. `done` rises W cycles after the accepting edge, where W is the sum over chunks of max(1, high−low+1). `busy` stays high from acceptance until `done`, and `done_status`/`done_id` hold steady meanwhile.
- R10: `done` is a single-cycle pulse after which `busy` falls. A command presented while `busy` is high is ignored.
- R11: The lookup port returns the entry at (`lk_chunk`, `lk_value`) on `lk_vec` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_del | input | 1 | 0 = add, 1 = delete |
| cmd_id | input | ID_W (3) | Slot to delete; ignored for add |
| cmd_lo | input | NUM_CHUNKS*CHUNK_W (104) | Low bounds, chunk k in bits [8k+7:8k] |
| cmd_hi | input | NUM_CHUNKS*CHUNK_W (104) | High bounds, same packing |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 success, 1 table full, 2 no such rule |
| done_id | output | ID_W (3) | Slot added or deleted |
| lk_chunk | input | CIDX_W (4) | Lookup chunk index |
| lk_value | input | CHUNK_W (8) | Lookup chunk value |
| lk_vec | output | NUM_RULES (8) | Registered membership word |

## Verification
Rules are added with ranges that step across the chunks. A second rule overlaps the first and has one empty chunk, so a whole-table scan can tell a correct OR apart from an overwrite, and a skipped chunk apart from one that wrapped. A delete followed by an add shows that the AND touches only one bit and that the freed slot is reused. A delete aimed at an unused slot, and an add after the table fills, show that the error paths write nothing. A full 0..255 range in chunk 0 exercises the end-of-range boundary. A command issued mid-walk shows that input is ignored while busy, and the measured walk lengths pin the one-write-per-cycle schedule.

// File: rtl/rupd_pkg.sv
package rupd_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_FULL    = 2'd1,
        ST_NO_RULE = 2'd2
    } upd_status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WALK = 2'd1,
        S_DONE = 2'd2
    } upd_state_e;

endpackage

// File: rtl/rupd_slot_alloc.sv
module rupd_slot_alloc #(
    parameter int NUM_RULES = 8,
    parameter int ID_W      = $clog2(NUM_RULES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [ID_W-1:0] set_id,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_id,
    input  logic [ID_W-1:0] query_id,
    output logic [ID_W-1:0] free_id,
    output logic            full,
    output logic            query_used
);

    logic [NUM_RULES-1:0] used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            if (set_en) used_q[set_id] <= 1'b1;
            if (clr_en) used_q[clr_id] <= 1'b0;
        end
    end

    // lowest-index free slot wins
    always_comb begin
        free_id = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (!used_q[i]) free_id = ID_W'(i);
        end
    end

    assign full       = &used_q;
    assign query_used = used_q[query_id];

endmodule

// File: rtl/rupd_range_walk.sv
module rupd_range_walk #(
    parameter int NUM_CHUNKS = 13,
    parameter int CHUNK_W    = 8,
    parameter int CIDX_W     = $clog2(NUM_CHUNKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          step,
    input  logic [NUM_CHUNKS*CHUNK_W-1:0] lo_flat,
    input  logic [NUM_CHUNKS*CHUNK_W-1:0] hi_flat,
    output logic [CIDX_W-1:0]             cur_chunk,
    output logic [CHUNK_W-1:0]            cur_val,
    output logic [CHUNK_W-1:0]            cur_lo,
    output logic [CHUNK_W-1:0]            cur_hi,
    output logic                          cur_nonempty,
    output logic                          last_step
);

    localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CHUNKS - 1);

    logic [CHUNK_W-1:0] lo_in [NUM_CHUNKS];
    logic [CHUNK_W-1:0] hi_in [NUM_CHUNKS];
    logic [CHUNK_W-1:0] lo_q  [NUM_CHUNKS];
    logic [CHUNK_W-1:0] hi_q  [NUM_CHUNKS];
    logic [CIDX_W-1:0]  idx_q;
    logic [CHUNK_W-1:0] val_q;
    logic               chunk_end;
    logic [CIDX_W-1:0]  idx_nxt;

    genvar g;
    generate
        for (g = 0; g < NUM_CHUNKS; g++) begin : g_unpack
            assign lo_in[g] = lo_flat[g*CHUNK_W +: CHUNK_W];
            assign hi_in[g] = hi_flat[g*CHUNK_W +: CHUNK_W];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo_q[g] <= '0;
                    hi_q[g] <= '0;
                end else if (load) begin
                    lo_q[g] <= lo_in[g];
                    hi_q[g] <= hi_in[g];
                end
            end
        end
    endgenerate

    assign cur_lo       = lo_q[idx_q];
    assign cur_hi       = hi_q[idx_q];
    assign cur_nonempty = (cur_lo <= cur_hi);
    assign chunk_end    = !cur_nonempty || (val_q == cur_hi);
    assign last_step    = chunk_end && (idx_q == LAST_IDX);
    assign idx_nxt      = idx_q + CIDX_W'(1);
    assign cur_chunk    = idx_q;
    assign cur_val      = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            val_q <= '0;
        end else if (load) begin
            idx_q <= '0;
            val_q <= lo_in[0];
        end else if (step) begin
            if (chunk_end) begin
                if (!last_step) begin
                    idx_q <= idx_nxt;
                    val_q <= lo_q[idx_nxt];
                end
            end else begin
                val_q <= val_q + CHUNK_W'(1);
            end
        end
    end

endmodule

// File: rtl/rupd_bv_store.sv
module rupd_bv_store #(
    parameter int NUM_RULES  = 8,
    parameter int NUM_CHUNKS = 13,
    parameter int CHUNK_W    = 8,
    parameter int CIDX_W     = $clog2(NUM_CHUNKS),
    parameter int ID_W       = $clog2(NUM_RULES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_clear,
    input  logic [ID_W-1:0]      wr_id,
    input  logic [CIDX_W-1:0]    wr_chunk,
    input  logic [CHUNK_W-1:0]   wr_val,
    input  logic [CIDX_W-1:0]    rd_chunk,
    input  logic [CHUNK_W-1:0]   rd_val,
    output logic [NUM_RULES-1:0] rd_vec
);

    localparam int DEPTH = 1 << CHUNK_W;

    logic [NUM_RULES-1:0] mem [NUM_CHUNKS][DEPTH];
    logic [NUM_RULES-1:0] bit_mask;
    logic [NUM_RULES-1:0] old_word;
    logic [NUM_RULES-1:0] new_word;

    assign bit_mask = NUM_RULES'(1) << wr_id;
    assign old_word = mem[wr_chunk][wr_val];
    assign new_word = wr_clear ? (old_word & ~bit_mask) : (old_word | bit_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CHUNKS; c++) begin
                for (int v = 0; v < DEPTH; v++) begin
                    mem[c][v] <= '0;
                end
            end
            rd_vec <= '0;
        end else begin
            if (wr_en) mem[wr_chunk][wr_val] <= new_word;
            rd_vec <= mem[rd_chunk][rd_val];
        end
    end

endmodule

// File: rtl/rule_update_engine.sv
module rule_update_engine
    import rupd_pkg::*;
#(
    parameter int NUM_RULES  = 8,
    parameter int NUM_CHUNKS = 13,
    parameter int CHUNK_W    = 8,
    parameter int ID_W       = $clog2(NUM_RULES),
    parameter int CIDX_W     = $clog2(NUM_CHUNKS),
    parameter int KEY_W      = NUM_CHUNKS * CHUNK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_del,
    input  logic [ID_W-1:0]      cmd_id,
    input  logic [KEY_W-1:0]     cmd_lo,
    input  logic [KEY_W-1:0]     cmd_hi,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           done_status,
    output logic [ID_W-1:0]      done_id,
    input  logic [CIDX_W-1:0]    lk_chunk,
    input  logic [CHUNK_W-1:0]   lk_value,
    output logic [NUM_RULES-1:0] lk_vec
);

    upd_state_e         state_q, state_nxt;
    upd_status_e        status_q;
    logic [ID_W-1:0]    id_q;
    logic               del_q;

    logic               accept;
    logic               slot_set, slot_clr;
    logic [ID_W-1:0]    free_id;
    logic               tbl_full, id_used;

    logic               walk_load, walk_step;
    logic [CIDX_W-1:0]  walk_chunk;
    logic [CHUNK_W-1:0] walk_val, walk_lo, walk_hi;
    logic               walk_nonempty, walk_last;
    logic               wr_en;

    rupd_slot_alloc #(.NUM_RULES(NUM_RULES), .ID_W(ID_W)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (slot_set),
        .set_id     (free_id),
        .clr_en     (slot_clr),
        .clr_id     (cmd_id),
        .query_id   (cmd_id),
        .free_id    (free_id),
        .full       (tbl_full),
        .query_used (id_used)
    );

    rupd_range_walk #(.NUM_CHUNKS(NUM_CHUNKS), .CHUNK_W(CHUNK_W), .CIDX_W(CIDX_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (walk_load),
        .step         (walk_step),
        .lo_flat      (cmd_lo),
        .hi_flat      (cmd_hi),
        .cur_chunk    (walk_chunk),
        .cur_val      (walk_val),
        .cur_lo       (walk_lo),
        .cur_hi       (walk_hi),
        .cur_nonempty (walk_nonempty),
        .last_step    (walk_last)
    );

    rupd_bv_store #(
        .NUM_RULES(NUM_RULES), .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_W(CHUNK_W),
        .CIDX_W(CIDX_W), .ID_W(ID_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_clear (del_q),
        .wr_id    (id_q),
        .wr_chunk (walk_chunk),
        .wr_val   (walk_val),
        .rd_chunk (lk_chunk),
        .rd_val   (lk_value),
        .rd_vec   (lk_vec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nxt;
    end

    // next state and datapath strobes
    always_comb begin
        state_nxt = state_q;
        accept    = 1'b0;
        slot_set  = 1'b0;
        slot_clr  = 1'b0;
        walk_load = 1'b0;
        walk_step = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    if (cmd_del) begin
                        if (id_used) begin
                            slot_clr  = 1'b1;
                            walk_load = 1'b1;
                            state_nxt = S_WALK;
                        end else begin
                            state_nxt = S_DONE;
                        end
                    end else begin
                        if (tbl_full) begin
                            state_nxt = S_DONE;
                        end else begin
                            slot_set  = 1'b1;
                            walk_load = 1'b1;
                            state_nxt = S_WALK;
                        end
                    end
                end
            end
            S_WALK: begin
                walk_step = 1'b1;
                wr_en     = walk_nonempty;
                if (walk_last) state_nxt = S_DONE;
            end
            S_DONE: begin
                state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // result registers captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            id_q     <= '0;
            del_q    <= 1'b0;
        end else if (accept) begin
            del_q <= cmd_del;
            if (cmd_del) begin
                id_q     <= cmd_id;
                status_q <= id_used ? ST_OK : ST_NO_RULE;
            end else begin
                id_q     <= tbl_full ? '0 : free_id;
                status_q <= tbl_full ? ST_FULL : ST_OK;
            end
        end
    end

    assign busy        = (state_q != S_IDLE);
    assign done        = (state_q == S_DONE);
    assign done_status = status_q;
    assign done_id     = id_q;

endmodule

// File: rtl/rupd_checker.sv
module rupd_checker #(
    parameter int CHUNK_W = 8,
    parameter int ID_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               busy,
    input logic               done,
    input logic [1:0]         done_status,
    input logic [ID_W-1:0]    done_id,
    input logic               wr_en,
    input logic [CHUNK_W-1:0] walk_val,
    input logic [CHUNK_W-1:0] walk_lo,
    input logic [CHUNK_W-1:0] walk_hi
);

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: engine returns to idle right after the pulse
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9: an accepted command raises busy on the next cycle
    a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R9: the reported result does not move while the command runs
    a_r9_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(done_status) && $stable(done_id)));

    // R7: writes only land inside a non-empty chunk range
    a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (walk_lo <= walk_hi && walk_val >= walk_lo && walk_val <= walk_hi));

    // R1: nothing is busy coming out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy || rst_n));

endmodule

bind rule_update_engine rupd_checker #(.CHUNK_W(CHUNK_W), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .busy        (busy),
    .done        (done),
    .done_status (done_status),
    .done_id     (done_id),
    .wr_en       (wr_en),
    .walk_val    (walk_val),
    .walk_lo     (walk_lo),
    .walk_hi     (walk_hi)
);

// File: tb/rule_update_engine_bench.sv
module rule_update_engine_bench;

    localparam int NR = 8;
    localparam int NC = 13;
    localparam int CW = 8;
    localparam int IW = 3;
    localparam int XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_del = 1'b0;
    logic [IW-1:0] cmd_id = '0;
    logic [NC*CW-1:0] cmd_lo = '0;
    logic [NC*CW-1:0] cmd_hi = '0;
    logic          busy, done;
    logic [1:0]    done_status;
    logic [IW-1:0] done_id;
    logic [XW-1:0] lk_chunk = '0;
    logic [CW-1:0] lk_value = '0;
    logic [NR-1:0] lk_vec;

    int total = 0;
    int bad = 0;

    int lo [NC];
    int hi [NC];
    logic [NR-1:0] model [NC][256];

    always #10 clk = ~clk;

    rule_update_engine u_rule_update_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_del(cmd_del),
        .cmd_id(cmd_id), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .busy(busy),
        .done(done), .done_status(done_status), .done_id(done_id),
        .lk_chunk(lk_chunk), .lk_value(lk_value), .lk_vec(lk_vec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int walk_len();
        int w = 0;
        for (int c = 0; c < NC; c++) w += (lo[c] <= hi[c]) ? (hi[c] - lo[c] + 1) : 1;
        return w;
    endfunction

    task automatic model_apply(input bit del, input int id);
        for (int c = 0; c < NC; c++)
            if (lo[c] <= hi[c])
                for (int v = lo[c]; v <= hi[c]; v++) model[c][v][id] = !del;
    endtask

    task automatic do_cmd(input bit del, input int id,
                          output int st, output int rid, output int n);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            cmd_lo[c*CW +: CW] = CW'(lo[c]);
            cmd_hi[c*CW +: CW] = CW'(hi[c]);
        end
        cmd_del = del; cmd_id = IW'(id); cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(posedge clk); @(negedge clk); n++;
        end
        st = done_status; rid = done_id;
        @(posedge clk); @(negedge clk);
        chk(!done && !busy, "R10", "pulse ends, busy low", {done, busy}, 0);
    endtask

    task automatic rd(input int c, input int v, output logic [NR-1:0] vec);
        @(negedge clk);
        lk_chunk = XW'(c); lk_value = CW'(v);
        @(posedge clk); @(negedge clk);
        vec = lk_vec;
    endtask

    task automatic scan(input string req);
        logic [NR-1:0] vec;
        bit ok = 1;
        for (int c = 0; c < NC; c++)
            for (int v = 0; v < 256; v++) begin
                rd(c, v, vec);
                if (ok && vec !== model[c][v]) begin
                    ok = 0;
                    $display("FAIL %s table chunk %0d value %0d: actual=%0h expected=%0h",
                             req, c, v, vec, model[c][v]);
                end
            end
        total++;
        if (!ok) bad++;
    endtask

    task automatic t_reset();
        for (int c = 0; c < NC; c++)
            for (int v = 0; v < 256; v++) model[c][v] = '0;
        chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);
        scan("R1");
    endtask

    task automatic t_add_first();
        int st, rid, n;
        for (int c = 0; c < NC; c++) begin lo[c] = c*3; hi[c] = c*3 + 2; end
        do_cmd(0, 0, st, rid, n);
        chk(st == 0 && rid == 0, "R2", "first add slot", rid, 0);
        chk(n == walk_len(), "R9", "walk cycles", n, walk_len());
        model_apply(0, 0);
        scan("R3");
    endtask

    task automatic t_add_overlap_empty();
        int st, rid, n;
        for (int c = 0; c < NC; c++) begin lo[c] = c*3 + 1; hi[c] = c*3 + 4; end
        lo[5] = 10; hi[5] = 9;  // empty range
        do_cmd(0, 0, st, rid, n);
        chk(st == 0 && rid == 1, "R2", "second add slot", rid, 1);
        chk(n == walk_len(), "R9", "walk cycles with empty chunk", n, walk_len());
        model_apply(0, 1);
        scan("R7_R8");
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        for (int c = 0; c < NC; c++) begin lo[c] = 200; hi[c] = 201; end
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            cmd_lo[c*CW +: CW] = 8'd200; cmd_hi[c*CW +: CW] = 8'd201;
        end
        cmd_del = 1'b0; cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk); cmd_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        // delete of slot 0 while busy must be ignored (R10)
        cmd_del = 1'b1; cmd_id = 3'd0; cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk); cmd_valid = 1'b0; cmd_del = 1'b0;
        while (!done && n < 3000) begin @(posedge clk); @(negedge clk); n++; end
        chk(done_id == 2 && done_status == 0, "R10", "add while poked", done_id, 2);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            chk(!done && !busy, "R10", "no second command", {done, busy}, 0);
        end
        model_apply(0, 2);
        scan("R10");
    endtask

    task automatic t_delete_reuse();
        int st, rid, n;
        for (int c = 0; c < NC; c++) begin lo[c] = c*3 + 1; hi[c] = c*3 + 4; end
        lo[5] = 10; hi[5] = 9;
        do_cmd(1, 1, st, rid, n);
        chk(st == 0 && rid == 1, "R5", "delete status", st, 0);
        model_apply(1, 1);
        scan("R5");
        for (int c = 0; c < NC; c++) begin lo[c] = 100 + c; hi[c] = 100 + c; end
        do_cmd(0, 0, st, rid, n);
        chk(rid == 1 && st == 0, "R5", "freed slot reused", rid, 1);
        model_apply(0, 1);
    endtask

    task automatic t_delete_unused();
        int st, rid, n;
        for (int c = 0; c < NC; c++) begin lo[c] = 0; hi[c] = 255; end
        do_cmd(1, 5, st, rid, n);
        chk(st == 2, "R6", "unused delete status", st, 2);
        chk(n == 0, "R6", "unused delete latency", n, 0);
        scan("R6");
    endtask

    task automatic t_fill_full();
        int st, rid, n;
        for (int k = 3; k < NR; k++) begin
            for (int c = 0; c < NC; c++) begin lo[c] = 50 + k; hi[c] = 50 + k; end
            if (k == 3) begin lo[0] = 0; hi[0] = 255; end
            do_cmd(0, 0, st, rid, n);
            chk(rid == k && st == 0, "R2", "fill slot", rid, k);
            if (k == 3) chk(n == walk_len(), "R9", "full-span chunk", n, walk_len());
            model_apply(0, k);
        end
        for (int c = 0; c < NC; c++) begin lo[c] = 30; hi[c] = 40; end
        do_cmd(0, 0, st, rid, n);
        chk(st == 1, "R4", "full status", st, 1);
        chk(n == 0, "R4", "full latency", n, 0);
        scan("R4_R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_add_first();
        t_add_overlap_empty();
        t_busy_ignore();
        t_delete_reuse();
        t_delete_unused();
        t_fill_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule